// File: doc/BRIEF.md
# Memory Controller Command Sequencer

This block is the control state machine of a DDR3-style memory controller. It walks the controller from reset through a long impedance calibration into an idle state. From there it serves maintenance requests (refresh, short calibration, write leveling) and the row-open, read, write and close cycle of normal access. It works in the controller's clock domain. On each cycle it drives a one-hot state vector and a command code for a downstream PHY model.

Some transitions are automatic. They fire when a wait counter inside the block expires, or when a done flag arrives from outside: initialisation done, leveling done, or burst done. The other transitions are driven by requests. A request is taken only in a state where it is legal. Any other request is dropped and answered with a one-cycle error pulse. Reads and writes can repeat in place, and they can swap direction through the auto-precharge variants. The kind of the last accepted access decides where the block goes when the burst ends.

All outputs are registered. A command appears in the same cycle as the state it leads into. Every cycle that carries no command shows NOP.

Top module: `mem_cmd_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows state RESET (`state_oh` = 1), `cmd` = NOP (0) and `err` = 0. `state_oh` always has exactly one bit set. The bit positions are: RESET 0, INIT 1, ZQ_CAL 2, IDLE 3, WRITE_LEVEL 4, REFRESH 5, ACTIVATE 6, BANK_ACTIVE 7, READ_OP 8, WRITE_OP 9, PRECHARGE 10.
- R2: RESET moves to INIT on the first edge with `rst` low, and emits NOP.
- R3: INIT waits for `init_done`, then enters ZQ_CAL and emits the long calibration command ZQCL (1). ZQ_CAL then lasts `ZQL_CYC` cycles and returns to IDLE with NOP.
- R4: In IDLE, a refresh request enters REFRESH and emits REF (3). A short calibration request enters ZQ_CAL, emits ZQCS (2) and lasts `ZQS_CYC` cycles. A leveling request enters WRITE_LEVEL and emits MRS (4). An activate request enters ACTIVATE and emits ACT (5).
- R5: The timed states return with NOP after a fixed number of cycles: REFRESH to IDLE after `RFC_CYC` cycles, ACTIVATE to BANK_ACTIVE after `RCD_CYC` cycles, and PRECHARGE to IDLE after `RP_CYC` cycles.
- R6: WRITE_LEVEL stays in place until `lvl_done` is seen, then returns to IDLE and emits MRS (4).
- R7: In BANK_ACTIVE, a read request enters READ_OP and emits RD (6). A write request enters WRITE_OP and emits WR (7). A precharge request enters PRECHARGE and emits PRE (10).
- R8: In READ_OP, a read request stays in READ_OP and emits RD. A write-with-auto-precharge request enters WRITE_OP and emits WRA (9). In WRITE_OP, a write request stays and emits WR. A read-with-auto-precharge request enters READ_OP and emits RDA (8). A precharge request in either state enters PRECHARGE and emits PRE.
- R9: `burst_done` in READ_OP or WRITE_OP overrides any request. The block goes to PRECHARGE if the last accepted access was an auto-precharge variant, and to BANK_ACTIVE otherwise, with NOP in both cases.
- R10: The request bus `req` uses these bits: 0 precharge, 1 refresh, 2 short calibration, 3 leveling, 4 activate, 5 read, 6 write, 7 read-auto-precharge, 8 write-auto-precharge. Only the lowest set bit is considered. If no request is accepted while `req` is non-zero, the request is ignored and `err` goes high for that one cycle.
- R11: A command other than NOP appears only in a cycle where the state changed, or on a repeated RD or WR in place. Every other cycle emits NOP (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset, forces RESET |
| req | input | 9 | Request strobes, one bit per request kind |
| init_done | input | 1 | Initialisation wait finished |
| lvl_done | input | 1 | Write leveling finished |
| burst_done | input | 1 | Current read or write burst finished |
| state_oh | output | 11 | One-hot current state |
| cmd | output | 4 | Command code issued this cycle |
| err | output | 1 | One-cycle pulse for an ignored request |

## Verification
A wrong internal state shows up at the ports on the very next cycle, through one of three outputs. `state_oh` moves to a different bit. `cmd` carries a code that does not fit the transition. `err` rises on a request that should have been accepted. A corrupted wait counter or a lost auto-precharge flag shows only when the timed state is left one cycle early or late, or when a burst ends in the wrong state. For that reason the reference model is compared with all three outputs on every cycle, and the stimulus runs every timed state to its end and every burst through both kinds of exit.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int NUM_ST  = 11;
  localparam int NUM_REQ = 9;

  typedef enum logic [3:0] {
    ST_RESET = 4'd0, ST_INIT = 4'd1, ST_ZQ = 4'd2, ST_IDLE = 4'd3,
    ST_LEVEL = 4'd4, ST_REFRESH = 4'd5, ST_ACT = 4'd6, ST_OPEN = 4'd7,
    ST_READ = 4'd8, ST_WRITE = 4'd9, ST_PRE = 4'd10
  } st_e;

  typedef enum logic [3:0] {
    CMD_NOP = 4'd0, CMD_ZQL = 4'd1, CMD_ZQS = 4'd2, CMD_REF = 4'd3,
    CMD_MRS = 4'd4, CMD_ACT = 4'd5, CMD_RD = 4'd6, CMD_WR = 4'd7,
    CMD_RDA = 4'd8, CMD_WRA = 4'd9, CMD_PRE = 4'd10
  } cmd_e;

  typedef enum logic [3:0] {
    RQ_PRE = 4'd0, RQ_REF = 4'd1, RQ_ZQS = 4'd2, RQ_LVL = 4'd3, RQ_ACT = 4'd4,
    RQ_RD = 4'd5, RQ_WR = 4'd6, RQ_RDA = 4'd7, RQ_WRA = 4'd8, RQ_NONE = 4'd9
  } rq_e;
endpackage

// File: rtl/mcs_req_pick.sv
module mcs_req_pick
  import mcs_pkg::*;
#(
  parameter int N = NUM_REQ
) (
  input  logic [N-1:0] req,
  output rq_e          pick
);
  // R10: the lowest set request bit wins
  always_comb begin
    pick = RQ_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) pick = rq_e'(4'(i));
    end
  end
endmodule

// File: rtl/mcs_wait_timer.sv
module mcs_wait_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

  // R5: an unloaded counter steps down by exactly one per cycle
  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/mem_cmd_seq.sv
module mem_cmd_seq
  import mcs_pkg::*;
#(
  parameter int ZQL_CYC = 16,
  parameter int ZQS_CYC = 4,
  parameter int RFC_CYC = 8,
  parameter int RCD_CYC = 3,
  parameter int RP_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_REQ-1:0] req,
  input  logic              init_done,
  input  logic              lvl_done,
  input  logic              burst_done,
  output logic [NUM_ST-1:0] state_oh,
  output logic [3:0]        cmd,
  output logic              err
);
  localparam int M1 = (ZQL_CYC > ZQS_CYC) ? ZQL_CYC : ZQS_CYC;
  localparam int M2 = (RFC_CYC > RCD_CYC) ? RFC_CYC : RCD_CYC;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > RP_CYC) ? M3 : RP_CYC;
  localparam int CW = $clog2(MAXC + 1);

  st_e   st_q, st_d;
  logic  ap_q, ap_d;
  cmd_e  cmd_d, cmd_q;
  logic  acc, tload, tdone, err_q;
  logic [CW-1:0] tval;
  logic [NUM_ST-1:0] oh_q;
  rq_e   pick;

  mcs_req_pick #(.N(NUM_REQ)) u_pick (.req(req), .pick(pick));

  mcs_wait_timer #(.W(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tload), .val(tval), .done(tdone)
  );

  always_comb begin
    st_d  = st_q;
    ap_d  = ap_q;
    cmd_d = CMD_NOP;
    acc   = 1'b0;
    tload = 1'b0;
    tval  = '0;
    unique case (st_q)
      ST_RESET: st_d = ST_INIT;
      ST_INIT: if (init_done) begin
        st_d = ST_ZQ; cmd_d = CMD_ZQL; tload = 1'b1; tval = CW'(ZQL_CYC - 1);
      end
      ST_ZQ, ST_REFRESH, ST_PRE: if (tdone) st_d = ST_IDLE;
      ST_ACT: if (tdone) st_d = ST_OPEN;
      ST_LEVEL: if (lvl_done) begin st_d = ST_IDLE; cmd_d = CMD_MRS; end
      ST_IDLE: begin
        acc = 1'b1;
        case (pick)
          RQ_REF: begin st_d = ST_REFRESH; cmd_d = CMD_REF; tload = 1'b1; tval = CW'(RFC_CYC - 1); end
          RQ_ZQS: begin st_d = ST_ZQ; cmd_d = CMD_ZQS; tload = 1'b1; tval = CW'(ZQS_CYC - 1); end
          RQ_LVL: begin st_d = ST_LEVEL; cmd_d = CMD_MRS; end
          RQ_ACT: begin st_d = ST_ACT; cmd_d = CMD_ACT; tload = 1'b1; tval = CW'(RCD_CYC - 1); end
          default: acc = 1'b0;
        endcase
      end
      ST_OPEN: begin
        acc = 1'b1;
        case (pick)
          RQ_RD:  begin st_d = ST_READ;  cmd_d = CMD_RD; ap_d = 1'b0; end
          RQ_WR:  begin st_d = ST_WRITE; cmd_d = CMD_WR; ap_d = 1'b0; end
          RQ_PRE: begin st_d = ST_PRE; cmd_d = CMD_PRE; tload = 1'b1; tval = CW'(RP_CYC - 1); end
          default: acc = 1'b0;
        endcase
      end
      ST_READ, ST_WRITE: begin
        if (burst_done) begin
          if (ap_q) begin st_d = ST_PRE; tload = 1'b1; tval = CW'(RP_CYC - 1); end
          else st_d = ST_OPEN;
        end else begin
          acc = 1'b1;
          if (pick == RQ_PRE) begin
            st_d = ST_PRE; cmd_d = CMD_PRE; tload = 1'b1; tval = CW'(RP_CYC - 1);
          end else if (st_q == ST_READ && pick == RQ_RD) begin
            cmd_d = CMD_RD; ap_d = 1'b0;
          end else if (st_q == ST_READ && pick == RQ_WRA) begin
            st_d = ST_WRITE; cmd_d = CMD_WRA; ap_d = 1'b1;
          end else if (st_q == ST_WRITE && pick == RQ_WR) begin
            cmd_d = CMD_WR; ap_d = 1'b0;
          end else if (st_q == ST_WRITE && pick == RQ_RDA) begin
            st_d = ST_READ; cmd_d = CMD_RDA; ap_d = 1'b1;
          end else acc = 1'b0;
        end
      end
      default: st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RESET;
      ap_q  <= 1'b0;
      cmd_q <= CMD_NOP;
      err_q <= 1'b0;
      oh_q  <= NUM_ST'(1);
    end else begin
      st_q  <= st_d;
      ap_q  <= ap_d;
      cmd_q <= cmd_d;
      err_q <= (|req) & ~acc;
      oh_q  <= NUM_ST'(1) << st_d;
    end
  end

  assign state_oh = oh_q;
  assign cmd      = cmd_q;
  assign err      = err_q;

  // R1: reset forces the RESET state and a quiet output
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (state_oh == NUM_ST'(1) && cmd == 4'd0 && !err));
  // R1: exactly one state bit
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst) $onehot(state_oh));
  // R2: RESET always hands over to INIT
  a_r2_reset_to_init: assert property (@(posedge clk) disable iff (rst)
    state_oh[ST_RESET] |=> state_oh[ST_INIT]);
  // R3: the step from INIT into calibration carries the long calibration command
  a_r3_init_zql: assert property (@(posedge clk) disable iff (rst)
    (state_oh[ST_ZQ] && $past(state_oh[ST_INIT])) |-> cmd == CMD_ZQL);
  // R4: calibration entered from IDLE carries the short command
  a_r4_idle_zqs: assert property (@(posedge clk) disable iff (rst)
    (state_oh[ST_ZQ] && $past(state_oh[ST_IDLE])) |-> cmd == CMD_ZQS);
  // R11: commands only on a move or an in-place read/write
  a_r11_cmd_on_move: assert property (@(posedge clk) disable iff (rst)
    (cmd != 4'd0) |-> (state_oh != $past(state_oh) || cmd == CMD_RD || cmd == CMD_WR));
endmodule

// File: tb/tb_mem_cmd_seq.sv
module tb_mem_cmd_seq;
  localparam int ZQL = 16, ZQS = 4, RFC = 8, RCD = 3, RP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] req = '0;
  logic init_done = 1'b0, lvl_done = 1'b0, burst_done = 1'b0;
  logic [10:0] state_oh;
  logic [3:0] cmd;
  logic err;

  mem_cmd_seq #(.ZQL_CYC(ZQL), .ZQS_CYC(ZQS), .RFC_CYC(RFC), .RCD_CYC(RCD), .RP_CYC(RP)) dut (
    .clk(clk), .rst(rst), .req(req), .init_done(init_done), .lvl_done(lvl_done),
    .burst_done(burst_done), .state_oh(state_oh), .cmd(cmd), .err(err)
  );

  always #10 clk = ~clk;  // 50 MHz

  int tests = 0, fails = 0, cycles = 0;
  bit started = 0, done_flag = 0;

  // behavioural reference: state numbers follow the R1 bit positions
  int m_st = 0, m_cmd = 0, m_prev = 0, m_left = 0;
  bit m_err = 0, m_ap = 0;

  function automatic int lowest(logic [8:0] r);
    for (int i = 0; i < 9; i++) if (r[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    int p;
    bit took;
    m_prev = m_st;
    if (rst) begin
      m_st = 0; m_cmd = 0; m_err = 0; m_ap = 0; m_left = 0;
    end else begin
      p = lowest(req); took = 0; m_cmd = 0;
      case (m_st)
        0: m_st = 1;
        1: if (init_done) begin m_st = 2; m_cmd = 1; m_left = ZQL; end
        2, 5, 10: begin m_left--; if (m_left == 0) m_st = 3; end
        6: begin m_left--; if (m_left == 0) m_st = 7; end
        4: if (lvl_done) begin m_st = 3; m_cmd = 4; end
        3: begin
          took = 1;
          if (p == 1) begin m_st = 5; m_cmd = 3; m_left = RFC; end
          else if (p == 2) begin m_st = 2; m_cmd = 2; m_left = ZQS; end
          else if (p == 3) begin m_st = 4; m_cmd = 4; end
          else if (p == 4) begin m_st = 6; m_cmd = 5; m_left = RCD; end
          else took = 0;
        end
        7: begin
          took = 1;
          if (p == 5) begin m_st = 8; m_cmd = 6; m_ap = 0; end
          else if (p == 6) begin m_st = 9; m_cmd = 7; m_ap = 0; end
          else if (p == 0) begin m_st = 10; m_cmd = 10; m_left = RP; end
          else took = 0;
        end
        8, 9: begin
          if (burst_done) begin
            if (m_ap) begin m_st = 10; m_left = RP; end else m_st = 7;
          end else begin
            took = 1;
            if (p == 0) begin m_st = 10; m_cmd = 10; m_left = RP; end
            else if (m_st == 8 && p == 5) begin m_cmd = 6; m_ap = 0; end
            else if (m_st == 8 && p == 8) begin m_st = 9; m_cmd = 9; m_ap = 1; end
            else if (m_st == 9 && p == 6) begin m_cmd = 7; m_ap = 0; end
            else if (m_st == 9 && p == 7) begin m_st = 8; m_cmd = 8; m_ap = 1; end
            else took = 0;
          end
        end
        default: m_st = 0;
      endcase
      m_err = (req != 0) && !took;
    end
    started = 1;
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
      4: return "R6";  5, 6, 10: return "R5";  7: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !done_flag) begin
      tests++;
      if (state_oh !== (11'd1 << m_st)) begin
        fails++;
        $display("FAIL %s state: got %b expected %b", rst ? "R1" : tag_of(m_prev), state_oh, 11'd1 << m_st);
      end
      tests++;
      if (cmd !== 4'(m_cmd)) begin
        fails++;
        $display("FAIL R11 cmd (from state %0d): got %0d expected %0d", m_prev, cmd, m_cmd);
      end
      tests++;
      if (err !== m_err) begin
        fails++;
        $display("FAIL R10 err: got %b expected %b", err, m_err);
      end
    end
  end

  task automatic drive(logic [8:0] r, logic id, logic ld, logic bd);
    @(negedge clk);
    req = r; init_done = id; lvl_done = ld; burst_done = bd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive('0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      tests++; fails++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);                          // R1 reset state
    @(negedge clk); rst = 1'b0;       // R2 RESET to INIT
    idle(1);
    drive(9'b0_0001_0000, 0, 0, 0);   // R10 activate in INIT is ignored
    idle(2);
    drive('0, 1, 0, 0);               // R3 long calibration
    idle(ZQL + 2);
    drive(9'b0_0000_0010, 0, 0, 0);   // R4 refresh, R5 its wait
    idle(RFC + 1);
    drive(9'b0_0000_0100, 0, 0, 0);   // R4 short calibration
    idle(ZQS + 1);
    drive(9'b0_0000_1000, 0, 0, 0);   // R4 leveling
    idle(3);
    drive('0, 0, 1, 0);               // R6 leveling exit
    drive(9'b0_0001_0010, 0, 0, 0);   // R10 lowest bit wins: refresh
    idle(RFC + 1);
    drive(9'b0_0001_0000, 0, 0, 0);   // R5 activate wait
    idle(RCD + 1);
    drive(9'b0_1000_0000, 0, 0, 0);   // R10 read-auto-precharge illegal in BANK_ACTIVE
    drive(9'b0_0010_0000, 0, 0, 0);   // R7 read
    drive(9'b0_0010_0000, 0, 0, 0);   // R8 read again
    drive(9'b0_0100_0000, 0, 0, 0);   // R10 plain write illegal in READ_OP
    drive(9'b1_0000_0000, 0, 0, 0);   // R8 write-auto-precharge
    drive(9'b0_0100_0000, 0, 0, 1);   // R9 burst end overrides request, to PRECHARGE
    idle(RP + 1);
    drive(9'b0_0001_0000, 0, 0, 0);
    idle(RCD + 1);
    drive(9'b0_0100_0000, 0, 0, 0);   // R7 write
    drive(9'b0_0100_0000, 0, 0, 0);   // R8 write again
    drive(9'b0_1000_0000, 0, 0, 0);   // R8 read-auto-precharge
    drive('0, 0, 0, 1);               // R9 burst end after auto-precharge
    idle(RP + 1);
    drive(9'b0_0001_0000, 0, 0, 0);
    idle(RCD + 1);
    drive(9'b0_0100_0000, 0, 0, 0);
    drive(9'b0_1000_0000, 0, 0, 0);   // R8 swap to read with auto-precharge
    drive(9'b1_0000_0000, 0, 0, 0);   // R10 write-auto-precharge illegal in READ_OP? legal: swap back
    drive(9'b0_0100_0000, 0, 0, 0);
    drive('0, 0, 0, 1);               // R9 plain write last: back to BANK_ACTIVE
    drive(9'b0_0000_0001, 0, 0, 0);   // R7 precharge
    idle(RP + 1);
    drive(9'b0_0001_0000, 0, 0, 0);
    idle(RCD + 1);
    drive(9'b0_0010_0000, 0, 0, 0);
    drive(9'b0_0000_0001, 0, 0, 0);   // R8 explicit precharge from READ_OP
    drive(9'b0_0000_0010, 0, 0, 0);   // R10 refresh during PRECHARGE ignored
    idle(RP + 1);
    drive(9'b0_0001_0000, 0, 0, 0);   // R11 quiet cycles checked every clock
    idle(1);
    @(negedge clk); rst = 1'b1;       // R1 reset from an active state
    idle(2);
    @(negedge clk); rst = 1'b0;
    idle(4);
    finish_run();
  end
endmodule